// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block is the front end of a small script-driven DMA engine. The host writes a start address into the script pointer. The sequencer then reads the instruction at that address from memory, one 32-bit word per request/acknowledge read transaction. It splits the first word into an 8-bit command byte and a 24-bit byte count. The second word goes to a second-operand register. A third word, fetched only for the memory-to-memory move class, goes to a third-operand register.

Once the last word of an instruction is in place, the sequencer raises `instr_valid` and waits. The execute stage pulses `instr_done` to release it, and the next fetch then starts at the advanced pointer. A host write to the pointer at any time abandons the work in progress and restarts fetching at the new address.

Command bits [7:6] give the class: block move, I/O or register access, transfer control, and memory move or load/store. The memory move is the encoding 2'b11 with bit 5 clear. The same class value with bit 5 set is load/store, which takes two words.

Top module: `scr_fetch_seq`

## Requirements
- R1: A synchronous active-low reset clears the pointer, the command, count and operand registers and the sequencer state. After reset `rd_req` and `instr_valid` are low.
- R2: After reset the block makes no read request until the host writes the pointer. The cycle after that write, `rd_req` is high and `rd_addr` equals the written address.
- R3: Once raised, `rd_req` stays high with `rd_addr` unchanged until a cycle in which `rd_ack` is high. Only one word is requested at a time.
- R4: The first accepted word of an instruction loads `cmd_byte` from data bits [31:24] and `byte_count` from bits [23:0], both in the same clock edge.
- R5: The second accepted word loads `operand2`.
- R6: A third word is requested only when `cmd_byte[7:6]` is 2'b11 and `cmd_byte[5]` is 0, and it loads `operand3`. For every other command `operand3` keeps its value.
- R7: The pointer grows by 4 for each accepted word. `rd_addr` is the pointer, so after the last word the pointer addresses the next instruction.
- R8: After the last word, `instr_valid` stays high and `rd_req` stays low until `instr_done` is seen. The next cycle fetching resumes at the pointer.
- R9: A host pointer write aborts any fetch or pending instruction. An acknowledge in that same cycle is discarded, and fetching restarts at the new address.
- R10: `rd_ack` while no request is outstanding and `instr_done` while no instruction is valid have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the script pointer |
| host_addr | input | 32 | Start address written by the host |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Byte address of the word requested |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| instr_valid | output | 1 | Instruction ready for execution |
| instr_done | input | 1 | Execute stage has consumed the instruction |
| cmd_byte | output | 8 | Command byte of the current instruction |
| byte_count | output | 24 | Byte count of the current instruction |
| operand2 | output | 32 | Second instruction word |
| operand3 | output | 32 | Third instruction word (memory move only) |
| script_ptr | output | 32 | Current script pointer |

## Verification
A sequencer state that is wrong shows up in the very next cycle. It appears as `rd_req` or `instr_valid` at the wrong level, or as `rd_addr` off by a multiple of four. A wrong choice on the word count shows later, when the next instruction's command byte comes from an operand word, and that surfaces within one instruction.

The bench therefore compares every output against a behavioural model on every clock. The fetch latency is varied and the program mixes two- and three-word instructions, including the class that shares the memory move's top bits. Aborts and stray handshakes are placed at awkward points.

// File: rtl/scr_fetch_pkg.sv
package scr_fetch_pkg;

  localparam int CMD_W     = 8;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_OP2   = 3'd2,
    ST_OP3   = 3'd3,
    ST_READY = 3'd4
  } fetch_st_t;

  // Memory-to-memory move: class 2'b11 with bit 5 clear takes a third word
  function automatic logic needs_third(input logic [CMD_W-1:0] cmd);
    return (cmd[7:6] == 2'b11) && !cmd[5];
  endfunction

endpackage

// File: rtl/scr_ptr_reg.sv
module scr_ptr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] ptr
);
  import scr_fetch_pkg::*;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return p + AW'(WORD_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (advance) ptr <= step_ptr(ptr);
  end

endmodule

// File: rtl/scr_fetch_ctrl.sv
module scr_fetch_ctrl
  import scr_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             rd_ack,
  input  logic             instr_done,
  input  logic [CMD_W-1:0] cmd_cur,
  output logic             rd_req,
  output logic             instr_valid,
  output logic             word_accept,
  output logic             take_cmd,
  output logic             take_op2,
  output logic             take_op3
);

  fetch_st_t st, st_nx;

  assign rd_req      = (st == ST_CMD) || (st == ST_OP2) || (st == ST_OP3);
  assign instr_valid = (st == ST_READY);
  assign word_accept = rd_req && rd_ack && !host_wr;
  assign take_cmd    = word_accept && (st == ST_CMD);
  assign take_op2    = word_accept && (st == ST_OP2);
  assign take_op3    = word_accept && (st == ST_OP3);

  always_comb begin
    st_nx = st;
    if (host_wr) begin
      st_nx = ST_CMD;
    end else begin
      unique case (st)
        ST_IDLE:  st_nx = ST_IDLE;
        ST_CMD:   if (rd_ack) st_nx = ST_OP2;
        ST_OP2:   if (rd_ack) st_nx = needs_third(cmd_cur) ? ST_OP3 : ST_READY;
        ST_OP3:   if (rd_ack) st_nx = ST_READY;
        ST_READY: if (instr_done) st_nx = ST_CMD;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R8: a pending instruction never overlaps a memory request
  a_r8_no_req_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !rd_req);

endmodule

// File: rtl/scr_instr_regs.sv
module scr_instr_regs
  import scr_fetch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       rd_data,
  input  logic                take_cmd,
  input  logic                take_op2,
  input  logic                take_op3,
  output logic [CMD_W-1:0]    cmd_byte,
  output logic [DW-CMD_W-1:0] byte_count,
  output logic [DW-1:0]       operand2,
  output logic [DW-1:0]       operand3
);
  localparam int CNT_W = DW - CMD_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_byte   <= '0;
      byte_count <= '0;
      operand2   <= '0;
      operand3   <= '0;
    end else begin
      if (take_cmd) begin
        cmd_byte   <= rd_data[DW-1 -: CMD_W];
        byte_count <= rd_data[CNT_W-1:0];
      end
      if (take_op2) operand2 <= rd_data;
      if (take_op3) operand3 <= rd_data;
    end
  end

  // R6: the third operand register moves only on a third-word load
  a_r6_op3_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !take_op3 |=> $stable(operand3));

  // R4: command and count are loaded together or not at all
  a_r4_cmd_count_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !take_cmd |=> $stable(cmd_byte) && $stable(byte_count));

endmodule

// File: rtl/scr_fetch_seq.sv
module scr_fetch_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          instr_valid,
  input  logic          instr_done,
  output logic [7:0]    cmd_byte,
  output logic [DW-9:0] byte_count,
  output logic [DW-1:0] operand2,
  output logic [DW-1:0] operand3,
  output logic [AW-1:0] script_ptr
);
  import scr_fetch_pkg::*;

  logic word_accept, take_cmd, take_op2, take_op3;

  scr_fetch_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .rd_ack      (rd_ack),
    .instr_done  (instr_done),
    .cmd_cur     (cmd_byte),
    .rd_req      (rd_req),
    .instr_valid (instr_valid),
    .word_accept (word_accept),
    .take_cmd    (take_cmd),
    .take_op2    (take_op2),
    .take_op3    (take_op3)
  );

  scr_ptr_reg #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_wr),
    .load_val (host_addr),
    .advance  (word_accept),
    .ptr      (script_ptr)
  );

  scr_instr_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .take_cmd   (take_cmd),
    .take_op2   (take_op2),
    .take_op3   (take_op3),
    .cmd_byte   (cmd_byte),
    .byte_count (byte_count),
    .operand2   (operand2),
    .operand3   (operand3)
  );

  assign rd_addr = script_ptr;

  // R3: an unanswered request holds its level and address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !host_wr |=> rd_req && $stable(rd_addr));

  // R7: each accepted word moves the pointer one word forward
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_accept |=> script_ptr == $past(script_ptr) + AW'(WORD_BYTES));

  // R8: a ready instruction stays ready until released
  a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !instr_done && !host_wr |=> instr_valid);

  // R9: a host write restarts fetching at the written address
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> rd_req && rd_addr == $past(host_addr));

  // R10: without an accepted word or host write the pointer holds
  a_r10_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !word_accept && !host_wr |=> $stable(script_ptr));

endmodule

// File: tb/test_scr_fetch_seq.sv
`timescale 1ns/100ps
module test_scr_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_addr = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = 32'hDEAD_BEEF;
  logic        instr_valid;
  logic        instr_done = 1'b0;
  logic [7:0]  cmd_byte;
  logic [23:0] byte_count;
  logic [31:0] operand2, operand3, script_ptr;

  always #2.5 clk = ~clk;

  scr_fetch_seq i_scr_fetch_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .instr_valid(instr_valid), .instr_done(instr_done),
    .cmd_byte(cmd_byte), .byte_count(byte_count),
    .operand2(operand2), .operand3(operand3), .script_ptr(script_ptr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 0;

  // Behavioural reference: phase 0 idle, 1..3 word index, 4 ready
  int          m_phase = 0;
  logic [31:0] m_ptr = '0, m_op2 = '0, m_op3 = '0;
  logic [7:0]  m_cmd = '0;
  logic [23:0] m_cnt = '0;
  logic [31:0] mem [int unsigned];
  int          lat_cfg = 0;
  int          wait_cnt = 0;
  bit          auto_mem = 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {8'h02, a[23:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R3", "rd_req", 32'(rd_req), 32'(m_phase >= 1 && m_phase <= 3));
    chk("R8", "instr_valid", 32'(instr_valid), 32'(m_phase == 4));
    chk("R7", "script_ptr", script_ptr, m_ptr);
    if (m_phase >= 1 && m_phase <= 3) chk("R7", "rd_addr", rd_addr, m_ptr);
    chk("R4", "cmd_byte", 32'(cmd_byte), 32'(m_cmd));
    chk("R4", "byte_count", 32'(byte_count), 32'(m_cnt));
    chk("R5", "operand2", operand2, m_op2);
    chk("R6", "operand3", operand3, m_op3);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_phase = 0; m_ptr = '0; m_cmd = '0; m_cnt = '0; m_op2 = '0; m_op3 = '0;
    end else if (host_wr) begin
      m_ptr = host_addr; m_phase = 1;
    end else if (m_phase >= 1 && m_phase <= 3 && rd_ack) begin
      if (m_phase == 1) begin
        m_cmd = rd_data[31:24]; m_cnt = rd_data[23:0]; m_phase = 2;
      end else if (m_phase == 2) begin
        m_op2 = rd_data;
        m_phase = (m_cmd[7:6] == 2'b11 && m_cmd[5] == 1'b0) ? 3 : 4;
      end else begin
        m_op3 = rd_data; m_phase = 4;
      end
      m_ptr = m_ptr + 32'd4;
    end else if (m_phase == 4 && instr_done) begin
      m_phase = 1;
    end
  endtask

  // Drive memory response for the coming edge, then advance one cycle
  task automatic tick();
    if (auto_mem) begin
      rd_ack = 1'b0; rd_data = 32'hDEAD_BEEF;
      if (m_phase >= 1 && m_phase <= 3) begin
        if (wait_cnt >= lat_cfg) begin
          rd_ack = 1'b1; rd_data = mem_word(m_ptr); wait_cnt = 0;
        end else wait_cnt++;
      end
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    host_wr = 1'b0; instr_done = 1'b0;
    compare_all();
  endtask

  task automatic run_to_valid();
    for (int i = 0; i < 40 && m_phase != 4; i++) tick();
    chk("R8", "reached ready", 32'(instr_valid), 32'd1);
  endtask

  task automatic release_instr(input int hold);
    for (int i = 0; i < hold; i++) tick();
    chk("R8", "held valid", 32'(instr_valid), 32'd1);
    instr_done = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // Program: block move, memory move, load/store, transfer control
    mem[32'h100] = 32'h0100_0010; mem[32'h104] = 32'h2000_0000;
    mem[32'h108] = 32'hC000_0040; mem[32'h10C] = 32'h3000_1000; mem[32'h110] = 32'h3000_2000;
    mem[32'h114] = 32'hE000_0004; mem[32'h118] = 32'h0000_0044;
    mem[32'h11C] = 32'h8000_0000; mem[32'h120] = 32'h0000_0200;

    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();
    // R1: reset state
    chk("R1", "rd_req after reset", 32'(rd_req), 32'd0);
    chk("R1", "valid after reset", 32'(instr_valid), 32'd0);
    chk("R1", "ptr after reset", script_ptr, 32'd0);
    rst_n = 1'b1;
    tick();

    // R10 / R2: stray handshakes while idle do nothing
    auto_mem = 0;
    rd_ack = 1'b1; rd_data = 32'hFFFF_FFFF; instr_done = 1'b1;
    tick();
    rd_ack = 1'b0;
    tick(); tick();
    chk("R2", "no request before host write", 32'(rd_req), 32'd0);
    chk("R10", "cmd untouched by stray ack", 32'(cmd_byte), 32'd0);
    auto_mem = 1;

    // R2: host write starts fetching
    host_wr = 1'b1; host_addr = 32'h100; lat_cfg = 0;
    tick();
    chk("R2", "request after write", 32'(rd_req), 32'd1);
    chk("R2", "address after write", rd_addr, 32'h100);

    // Two-word block move, zero latency
    run_to_valid();
    chk("R4", "block move cmd", 32'(cmd_byte), 32'h01);
    chk("R5", "block move op2", operand2, 32'h2000_0000);
    chk("R7", "ptr after 2 words", script_ptr, 32'h108);
    // R10: stray ack while ready
    auto_mem = 0; rd_ack = 1'b1; rd_data = 32'h1234_5678;
    tick();
    rd_ack = 1'b0; auto_mem = 1;
    chk("R10", "op2 after stray ack", operand2, 32'h2000_0000);
    release_instr(2);

    // Three-word memory move, latency 2 (R3 hold)
    lat_cfg = 2; wait_cnt = 0;
    run_to_valid();
    chk("R6", "memory move op3", operand3, 32'h3000_2000);
    chk("R7", "ptr after 3 words", script_ptr, 32'h114);
    release_instr(1);

    // Load/store shares class bits but takes two words
    lat_cfg = 1; wait_cnt = 0;
    run_to_valid();
    chk("R6", "load/store leaves op3", operand3, 32'h3000_2000);
    chk("R7", "ptr after load/store", script_ptr, 32'h11C);
    release_instr(0);

    // Transfer control, zero latency
    lat_cfg = 0; wait_cnt = 0;
    run_to_valid();
    chk("R4", "transfer cmd", 32'(cmd_byte), 32'h80);
    chk("R4", "transfer count", 32'(byte_count), 32'h0);
    release_instr(3);

    // R9: abort mid-fetch with a simultaneous ack
    lat_cfg = 3; wait_cnt = 0;
    tick();                     // first word of default fill accepted or pending
    for (int i = 0; i < 40 && m_phase != 2; i++) tick();
    auto_mem = 0;
    host_wr = 1'b1; host_addr = 32'h108; rd_ack = 1'b1; rd_data = 32'h7777_7777;
    tick();
    rd_ack = 1'b0; auto_mem = 1; wait_cnt = 0;
    chk("R9", "restart address", rd_addr, 32'h108);
    chk("R9", "ack discarded", operand2, 32'h0000_0200);
    run_to_valid();
    chk("R9", "refetched memory move", operand3, 32'h3000_2000);

    // R9: host write while an instruction is pending
    host_wr = 1'b1; host_addr = 32'h100; lat_cfg = 0;
    tick();
    chk("R9", "ready dropped on write", 32'(instr_valid), 32'd0);
    run_to_valid();
    chk("R5", "refetched op2", operand2, 32'h2000_0000);
    release_instr(0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule